// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block sits between a set of peripheral interrupt sources and a small CPU. Each source owns a pending flag and a 3-bit priority level. A pulse on a source's event line latches its pending flag. From the pending flags, the levels, a global enable and a 3-bit processor threshold supplied by the CPU, the block picks one winning source. It presents a request together with the winner's index and level.

The CPU takes an interrupt by pulsing an acknowledge for one cycle, and the winner's pending flag drops. Software has two write paths. One loads the level of a chosen source. The other clears pending flags with a vector write, in which a written 0 clears a flag and a written 1 leaves it alone. Software can never raise a pending flag. The request, index and level outputs are combinational functions of registered state and of the enable and threshold inputs, so an acknowledge always refers to the index shown in that same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `glb_en` is 0, `irq_req` is 0, whatever the pending flags and levels hold.
- R2: A 1 on `src_evt[i]` at a clock edge makes source i pending from the next cycle.
- R3: `irq_ack` high at an edge while `irq_req` is 1 clears the pending flag of the source shown on `irq_vec`. `irq_ack` while `irq_req` is 0 changes nothing.
- R4: `pnd_wr_en` with `pnd_wr_data` clears every pending flag whose data bit is 0. A data bit of 1 has no effect and never sets a flag.
- R5: A level of 0 disables its source: that source never produces a request. `lvl_wr_en` loads `lvl_wr_data` into the level of source `lvl_wr_idx`, and the new level applies from the next cycle.
- R6: A pending, enabled source is eligible only if its level is strictly greater than `cpu_thr`. A `cpu_thr` of 7 blocks every source.
- R7: Among eligible sources, the highest level wins. On equal levels, the lowest index wins.
- R8: `irq_req` is 1 exactly when some source is eligible, in the same cycle, and `irq_vec`/`irq_lvl` give the winner's index and level. With no request, both are 0.
- R9: An event on a source in the same cycle as its clearing, whether by acknowledge or by software, leaves the flag at 1.
- R10: After reset, every pending flag and every level is 0, and `irq_req` is 0.
- R11: The enable, threshold, levels and pending flags are independent. Changing the enable, the threshold or a level never alters a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | N_SRC | Per-source request event, one bit per source |
| glb_en | input | 1 | Global maskable interrupt enable |
| cpu_thr | input | 3 | Processor priority threshold |
| irq_ack | input | 1 | One-cycle acceptance of the shown request |
| lvl_wr_en | input | 1 | Level write strobe |
| lvl_wr_idx | input | IDX_W | Source whose level is written |
| lvl_wr_data | input | 3 | New level value |
| pnd_wr_en | input | 1 | Pending clear strobe |
| pnd_wr_data | input | N_SRC | 0 clears that source's flag, 1 keeps it |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | IDX_W | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The assertions assume that `irq_ack` is a single-cycle pulse and that `lvl_wr_idx` names an existing source. They also assume that inputs settle between edges, since the request outputs follow `glb_en` and `cpu_thr` within the same cycle. The directed stimulus changes every input on the falling clock edge. It raises acknowledge for exactly one cycle, uses only source indices below `N_SRC`, and places event pulses on the very edge of a clear only in the collision scenario.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // A source level passes the processor threshold only when strictly above it.
  function automatic logic lvl_admits(input lvl_t lvl, input lvl_t thr);
    return lvl > thr;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] ack_hit,
  input  logic             sw_wr_en,
  input  logic [N_SRC-1:0] sw_wr_data,
  output logic [N_SRC-1:0] pnd_q
);
  logic [N_SRC-1:0] pnd_n;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic sw_clr;
    logic keep;
    assign sw_clr     = sw_wr_en & ~sw_wr_data[g];
    assign keep       = pnd_q[g] & ~ack_hit[g] & ~sw_clr;
    assign pnd_n[g]   = src_evt[g] | keep;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      src_evt[g] |=> pnd_q[g]); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ack_hit[g] && !src_evt[g]) |=> !pnd_q[g]); // R3
    AST_SW_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (!pnd_q[g] && !src_evt[g]) |=> !pnd_q[g]); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (src_evt[g] && (ack_hit[g] || sw_clr)) |=> pnd_q[g]); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) pnd_q <= '0;
    else     pnd_q <= pnd_n;
  end
endmodule

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  lvl_t                        wr_data,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_q
);
  localparam logic [IDX_W:0] SRC_CNT = (IDX_W+1)'(N_SRC);

  logic idx_ok;
  assign idx_ok = {1'b0, wr_idx} < SRC_CNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
    end else if (wr_en && idx_ok) begin
      lvl_q[wr_idx] <= wr_data;
    end
  end

  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lvl_q)); // R11
  AST_LVL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok) |=> lvl_q[$past(wr_idx)] == $past(wr_data)); // R5
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        glb_en,
  input  lvl_t                        thr,
  input  logic [N_SRC-1:0]            pnd,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_vec,
  output logic                        win_vld,
  output logic [IDX_W-1:0]            win_idx,
  output lvl_t                        win_lvl
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = glb_en & pnd[g] & lvl_admits(lvl_vec[g], thr);
  end

  // Linear scan: a later source replaces the holder only when strictly
  // higher, so equal levels keep the lowest index.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!win_vld || lvl_vec[i] > win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_vec[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             glb_en,
  input  logic [2:0]       cpu_thr,
  input  logic             irq_ack,
  input  logic             lvl_wr_en,
  input  logic [IDX_W-1:0] lvl_wr_idx,
  input  logic [2:0]       lvl_wr_data,
  input  logic             pnd_wr_en,
  input  logic [N_SRC-1:0] pnd_wr_data,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_vec,
  output logic [2:0]       irq_lvl
);
  logic [N_SRC-1:0]            pnd_q;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [N_SRC-1:0]            ack_hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign ack_hit[g] = irq_ack & irq_req & (irq_vec == IDX_W'(g));
  end

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .src_evt    (src_evt),
    .ack_hit    (ack_hit),
    .sw_wr_en   (pnd_wr_en),
    .sw_wr_data (pnd_wr_data),
    .pnd_q      (pnd_q)
  );

  irq_lvl_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (lvl_wr_en),
    .wr_idx  (lvl_wr_idx),
    .wr_data (lvl_wr_data),
    .lvl_q   (lvl_q)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .glb_en  (glb_en),
    .thr     (cpu_thr),
    .pnd     (pnd_q),
    .lvl_vec (lvl_q),
    .win_vld (irq_req),
    .win_idx (irq_vec),
    .win_lvl (irq_lvl)
  );

  AST_EN_GATES: assert property (@(posedge clk) disable iff (rst)
    !glb_en |-> !irq_req); // R1
  AST_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl > cpu_thr)); // R6
  AST_NONZERO_LVL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl != 3'd0)); // R5
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> pnd_q[irq_vec]); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0 && irq_lvl == '0)); // R8
  AST_ACK_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_hit)); // R3
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] src_evt;
  logic glb_en;
  logic [2:0] cpu_thr;
  logic irq_ack;
  logic lvl_wr_en;
  logic [IW-1:0] lvl_wr_idx;
  logic [2:0] lvl_wr_data;
  logic pnd_wr_en;
  logic [N-1:0] pnd_wr_data;
  logic irq_req;
  logic [IW-1:0] irq_vec;
  logic [2:0] irq_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_evt(src_evt), .glb_en(glb_en), .cpu_thr(cpu_thr),
    .irq_ack(irq_ack), .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx),
    .lvl_wr_data(lvl_wr_data), .pnd_wr_en(pnd_wr_en), .pnd_wr_data(pnd_wr_data),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expect a request from source v at level l, or none when v < 0.
  task automatic expect_irq(input string tag, input int v, input int l);
    if (v < 0) begin
      chk({tag, " req"}, int'(irq_req), 0);
      chk({tag, " vec"}, int'(irq_vec), 0);
      chk({tag, " lvl"}, int'(irq_lvl), 0);
    end else begin
      chk({tag, " req"}, int'(irq_req), 1);
      chk({tag, " vec"}, int'(irq_vec), v);
      chk({tag, " lvl"}, int'(irq_lvl), l);
    end
  endtask

  task automatic set_lvl(input int idx, input int v);
    lvl_wr_en = 1'b1; lvl_wr_idx = IW'(idx); lvl_wr_data = 3'(v);
    tick();
    lvl_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_evt = m;
    tick();
    src_evt = '0;
  endtask

  task automatic sw_clear(input logic [N-1:0] d, input logic [N-1:0] evt);
    pnd_wr_en = 1'b1; pnd_wr_data = d; src_evt = evt;
    tick();
    pnd_wr_en = 1'b0; src_evt = '0;
  endtask

  task automatic ack(input logic [N-1:0] evt);
    irq_ack = 1'b1; src_evt = evt;
    tick();
    irq_ack = 1'b0; src_evt = '0;
  endtask

  task automatic t_reset();
    expect_irq("R10 after reset", -1, 0);
    glb_en = 1'b1; cpu_thr = 3'd0;
    pulse('1);
    expect_irq("R5 R10 all levels zero", -1, 0);
    sw_clear('0, '0);
  endtask

  task automatic t_single();
    set_lvl(3, 4);
    expect_irq("R2 no event yet", -1, 0);
    pulse(8'b0000_1000);
    expect_irq("R2 R8 single source", 3, 4);
  endtask

  task automatic t_enable();
    glb_en = 1'b0; #1;
    expect_irq("R1 enable off", -1, 0);
    tick();
    glb_en = 1'b1; #1;
    expect_irq("R11 pending kept across enable", 3, 4);
  endtask

  task automatic t_threshold();
    cpu_thr = 3'd3; #1;
    expect_irq("R6 level 4 over thr 3", 3, 4);
    cpu_thr = 3'd4; #1;
    expect_irq("R6 level 4 at thr 4", -1, 0);
    set_lvl(3, 7);
    cpu_thr = 3'd7; #1;
    expect_irq("R6 thr 7 blocks level 7", -1, 0);
    tick();
    cpu_thr = 3'd0;
    set_lvl(3, 4);
    expect_irq("R11 pending kept across threshold", 3, 4);
  endtask

  task automatic t_priority();
    set_lvl(5, 6);
    pulse(8'b0010_0000);
    expect_irq("R7 higher level wins", 5, 6);
    set_lvl(1, 6);
    pulse(8'b0000_0010);
    expect_irq("R7 tie lowest index", 1, 6);
  endtask

  task automatic t_ack();
    ack('0);
    expect_irq("R3 ack clears 1", 5, 6);
    ack('0);
    expect_irq("R3 ack clears 5", 3, 4);
    glb_en = 1'b0;
    ack('0);
    glb_en = 1'b1; #1;
    expect_irq("R3 ack without request ignored", 3, 4);
    ack('0);
    expect_irq("R3 ack clears last", -1, 0);
  endtask

  task automatic t_sw();
    sw_clear('1, '0);
    expect_irq("R4 write ones sets nothing", -1, 0);
    pulse(8'b0010_1000);
    expect_irq("R4 setup", 5, 6);
    sw_clear('1, '0);
    expect_irq("R4 ones keep pending", 5, 6);
    sw_clear(8'b1101_1111, '0);
    expect_irq("R4 zero bit clears 5", 3, 4);
  endtask

  task automatic t_collide();
    ack(8'b0000_1000);
    expect_irq("R9 event beats ack", 3, 4);
    sw_clear(8'b1111_0111, 8'b0000_1000);
    expect_irq("R9 event beats sw clear", 3, 4);
  endtask

  task automatic t_level_write();
    set_lvl(3, 0);
    expect_irq("R5 level zero disables", -1, 0);
    set_lvl(3, 2);
    expect_irq("R11 R5 pending kept across level", 3, 2);
    sw_clear('0, '0);
    expect_irq("R4 clear all", -1, 0);
  endtask

  initial begin
    rst = 1'b1; src_evt = '0; glb_en = 1'b0; cpu_thr = '0; irq_ack = 1'b0;
    lvl_wr_en = 1'b0; lvl_wr_idx = '0; lvl_wr_data = '0;
    pnd_wr_en = 1'b0; pnd_wr_data = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_enable();
    t_threshold();
    t_priority();
    t_ack();
    t_sw();
    t_collide();
    t_level_write();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule